// File: doc/BRIEF.md
# Video Input Active-Window Framing Generator

This block sits at the front of a video input path. It watches a raw horizontal and vertical sync pair and produces the strobes that mark the active picture: a line-valid level for every active line, a pixel-valid level for every active pixel inside such a line, and a frame-start strobe on the very first active pixel of a field. The window is set by static configuration inputs. Each sync has its own polarity select. The vertical offset and the active line count come in units of one line and two lines respectively. The horizontal start is built from a coarse count of four-pixel steps, a fine phase of 0 to 3 pixels and a fixed 7-pixel pipeline allowance. The active width comes in units of eight pixels.

A low-active sample enable qualifies every clock edge. When it is tied low, every clock is a sample. When a half-rate clock drives it, every other clock is a sample, and all timing stretches by two. The block also counts lines per field and reports whether the source looks like a 525-line or a 625-line standard. The source must keep an even number of clocks between horizontal syncs. The vertical sequencer has four states:

- ST_WAIT_V: after reset. Leaves to ST_BLANK on the first vertical sync edge.
- ST_BLANK: offset lines. Leaves to ST_ACTIVE on the horizontal edge that starts line offset+1, if the line count is non-zero.
- ST_ACTIVE: active lines. Leaves to ST_DONE on the horizontal edge that starts line offset+2N+1.
- ST_DONE: rest of the field.

A vertical sync edge sends ST_BLANK, ST_ACTIVE and ST_DONE back to ST_BLANK.

Top module: `fw_framer`

## Requirements
- R1: Each sync input has its own polarity select (1 = active high, 0 = active low). Only a sampled change from the inactive level to the active level counts as a sync edge.
- R2: A clock edge at which `sync_en_n` is 1 samples nothing and advances nothing. With a half-rate enable, every timing figure below doubles when measured in clocks.
- R3: After reset, `line_valid`, `pixel_valid`, `frame_start` and `std_ntsc` are 0. The three framing outputs stay 0 until a vertical sync edge has been sampled.
- R4: Horizontal sync edges after a vertical sync edge number the lines 1, 2, 3 and so on. `line_valid` is 1 through lines `v_offset`+1 up to `v_offset`+2·`v_lines2`, and 0 on all other lines.
- R5: Let D = 4·`h_coarse` + `h_fine` + 7. `pixel_valid` first goes to 1 right after the D-th sample that follows the sample which first sees horizontal sync active.
- R6: On each active line, `pixel_valid` stays 1 for exactly 8·`h_blocks` consecutive samples. It is never 1 outside an active line.
- R7: `frame_start` is 1 only during the first `pixel_valid` sample of the first active line of each field.
- R8: At each vertical sync edge after the first, `std_ntsc` is set to 1 if fewer than 290 horizontal sync edges were counted since the previous vertical sync edge, and to 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_en_n | input | 1 | Sample enable, active low |
| hsync_in | input | 1 | Raw horizontal sync |
| vsync_in | input | 1 | Raw vertical sync |
| hs_pol | input | 1 | 1 = horizontal sync active high |
| vs_pol | input | 1 | 1 = vertical sync active high |
| v_offset | input | 10 | Lines from the vertical sync to the first active line |
| v_lines2 | input | 9 | Active lines per field divided by 2 |
| h_coarse | input | 8 | Horizontal start, coarse, in 4-pixel steps |
| h_fine | input | 2 | Horizontal start, fine phase in pixels |
| h_blocks | input | 8 | Active pixels per line divided by 8 |
| line_valid | output | 1 | Current line is active |
| pixel_valid | output | 1 | Current sample is an active pixel |
| frame_start | output | 1 | First active pixel of the field |
| std_ntsc | output | 1 | 1 = short field (525-line family), 0 = long field |

## Verification
A wrong sequencer state shows at the ports within one line: `line_valid` either comes up on lines outside the programmed band, or stays up with no band at all. A pixel counter that is off by one moves the first `pixel_valid` sample, or changes the number of active samples, on the very first active line. A wrong line count or threshold only shows in `std_ntsc` one field later, so every stimulus case runs two fields. The lengths are chosen to sit on both sides of the threshold: 262, 289, 290 and 312 lines.

// File: rtl/fw_pkg.sv
package fw_pkg;
    typedef enum logic [1:0] {
        ST_WAIT_V = 2'd0,
        ST_BLANK  = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_DONE   = 2'd3
    } vstate_e;

    localparam int SYNC_CH = 2;
    localparam int CH_H    = 0;
    localparam int CH_V    = 1;
endpackage

// File: rtl/fw_sampler.sv
module fw_sampler #(
    parameter int CH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sync_en_n,
    input  logic [CH-1:0] sync_raw,
    input  logic [CH-1:0] pol,
    output logic          tick,
    output logic [CH-1:0] rise
);
    assign tick = ~sync_en_n;

    for (genvar i = 0; i < CH; i++) begin : g_ch
        logic active_s;
        logic cur_q;
        logic prev_q;

        assign active_s = pol[i] ? sync_raw[i] : ~sync_raw[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cur_q  <= 1'b0;
                prev_q <= 1'b0;
            end else if (tick) begin
                cur_q  <= active_s;
                prev_q <= cur_q;
            end
        end

        assign rise[i] = tick & cur_q & ~prev_q;
    end
endmodule

// File: rtl/fw_hcount.sv
module fw_hcount #(
    parameter int COARSE_W = 8,
    parameter int BLOCKS_W = 8,
    parameter int PCNT_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                hs_rise,
    input  logic [COARSE_W-1:0] coarse,
    input  logic [1:0]          fine,
    input  logic [BLOCKS_W-1:0] blocks,
    output logic                in_window,
    output logic                at_first
);
    localparam logic [PCNT_W-1:0] PCNT_MAX   = {PCNT_W{1'b1}};
    localparam logic [PCNT_W-1:0] PIPE_SLACK = PCNT_W'(7);

    logic [PCNT_W-1:0] px_cnt;
    logic [PCNT_W-1:0] start_px;
    logic [PCNT_W-1:0] stop_px;

    always_comb begin
        start_px = (PCNT_W'(coarse) << 2) + PCNT_W'(fine) + PIPE_SLACK;
        stop_px  = start_px + (PCNT_W'(blocks) << 3);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            px_cnt <= '0;
        end else if (hs_rise) begin
            px_cnt <= PCNT_W'(1);
        end else if (tick && px_cnt != PCNT_MAX) begin
            px_cnt <= px_cnt + 1'b1;
        end
    end

    assign in_window = (px_cnt >= start_px) && (px_cnt < stop_px);
    assign at_first  = (px_cnt == start_px);
endmodule

// File: rtl/fw_vseq.sv
module fw_vseq
    import fw_pkg::*;
#(
    parameter int OFF_W      = 10,
    parameter int N_W        = 9,
    parameter int LCNT_W     = 11,
    parameter int NTSC_LIMIT = 290
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hs_rise,
    input  logic             vs_rise,
    input  logic [OFF_W-1:0] v_offset,
    input  logic [N_W-1:0]   v_lines2,
    output logic             line_active,
    output logic             first_line,
    output logic             std_flag
);
    localparam logic [LCNT_W-1:0] LCNT_MAX = {LCNT_W{1'b1}};
    localparam logic [LCNT_W-1:0] LIMIT    = LCNT_W'(NTSC_LIMIT);

    vstate_e           state;
    vstate_e           nxt;
    logic [LCNT_W-1:0] ln_cnt;
    logic [LCNT_W-1:0] nl;
    logic [LCNT_W-1:0] first_ln;
    logic [LCNT_W-1:0] end_ln;

    always_comb begin
        nl       = (ln_cnt == LCNT_MAX) ? ln_cnt : ln_cnt + 1'b1;
        first_ln = LCNT_W'(v_offset) + 1'b1;
        end_ln   = LCNT_W'(v_offset) + (LCNT_W'(v_lines2) << 1) + 1'b1;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_WAIT_V: begin
                if (vs_rise) nxt = ST_BLANK;
            end
            ST_BLANK: begin
                if (vs_rise)
                    nxt = ST_BLANK;
                else if (hs_rise && nl == first_ln && v_lines2 != '0)
                    nxt = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (vs_rise)
                    nxt = ST_BLANK;
                else if (hs_rise && nl == end_ln)
                    nxt = ST_DONE;
            end
            ST_DONE: begin
                if (vs_rise) nxt = ST_BLANK;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WAIT_V;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_cnt   <= '0;
            std_flag <= 1'b0;
        end else begin
            if (vs_rise) begin
                ln_cnt <= '0;
                if (state != ST_WAIT_V) std_flag <= (ln_cnt < LIMIT);
            end else if (hs_rise) begin
                ln_cnt <= nl;
            end
        end
    end

    always_comb begin
        line_active = 1'b0;
        first_line  = 1'b0;
        unique case (state)
            ST_WAIT_V: line_active = 1'b0;
            ST_BLANK:  line_active = 1'b0;
            ST_ACTIVE: begin
                line_active = 1'b1;
                first_line  = (ln_cnt == first_ln);
            end
            ST_DONE:   line_active = 1'b0;
        endcase
    end
endmodule

// File: rtl/fw_framer.sv
module fw_framer
    import fw_pkg::*;
#(
    parameter int OFF_W      = 10,
    parameter int N_W        = 9,
    parameter int COARSE_W   = 8,
    parameter int BLOCKS_W   = 8,
    parameter int NTSC_LIMIT = 290
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sync_en_n,
    input  logic                hsync_in,
    input  logic                vsync_in,
    input  logic                hs_pol,
    input  logic                vs_pol,
    input  logic [OFF_W-1:0]    v_offset,
    input  logic [N_W-1:0]      v_lines2,
    input  logic [COARSE_W-1:0] h_coarse,
    input  logic [1:0]          h_fine,
    input  logic [BLOCKS_W-1:0] h_blocks,
    output logic                line_valid,
    output logic                pixel_valid,
    output logic                frame_start,
    output logic                std_ntsc
);
    localparam int LCNT_W = ((OFF_W > N_W + 1) ? OFF_W : N_W + 1) + 1;
    localparam int PCNT_W = ((COARSE_W + 2 > BLOCKS_W + 3) ? COARSE_W + 2 : BLOCKS_W + 3) + 2;

    logic               tick;
    logic [SYNC_CH-1:0] rise;
    logic               in_window;
    logic               at_first;
    logic               first_line;

    fw_sampler #(.CH(SYNC_CH)) u_samp (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_en_n(sync_en_n),
        .sync_raw ({vsync_in, hsync_in}),
        .pol      ({vs_pol, hs_pol}),
        .tick     (tick),
        .rise     (rise)
    );

    fw_hcount #(.COARSE_W(COARSE_W), .BLOCKS_W(BLOCKS_W), .PCNT_W(PCNT_W)) u_hcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .hs_rise  (rise[CH_H]),
        .coarse   (h_coarse),
        .fine     (h_fine),
        .blocks   (h_blocks),
        .in_window(in_window),
        .at_first (at_first)
    );

    fw_vseq #(.OFF_W(OFF_W), .N_W(N_W), .LCNT_W(LCNT_W), .NTSC_LIMIT(NTSC_LIMIT)) u_vseq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hs_rise    (rise[CH_H]),
        .vs_rise    (rise[CH_V]),
        .v_offset   (v_offset),
        .v_lines2   (v_lines2),
        .line_active(line_valid),
        .first_line (first_line),
        .std_flag   (std_ntsc)
    );

    assign pixel_valid = line_valid & in_window;
    assign frame_start = pixel_valid & first_line & at_first;
endmodule

// File: rtl/fw_framer_chk.sv
module fw_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic sync_en_n,
    input logic vsync_in,
    input logic vs_pol,
    input logic line_valid,
    input logic pixel_valid,
    input logic frame_start,
    input logic std_ntsc
);
    logic seen_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_v <= 1'b0;
        else if (!sync_en_n && (vs_pol ? vsync_in : !vsync_in)) seen_v <= 1'b1;
    end

    assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_v |-> (!line_valid && !pixel_valid));

    assert_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sync_en_n |=> ($stable(line_valid) && $stable(pixel_valid) && $stable(std_ntsc)));

    assert_line_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_valid) |-> !pixel_valid);

    assert_pix_in_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pixel_valid |-> line_valid);

    assert_start_on_pix_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> pixel_valid);
endmodule

bind fw_framer fw_framer_chk u_chk (.*);

// File: tb/sim_fw_framer.sv
`timescale 1ns/1ps
module sim_fw_framer;
    localparam int LINE_S = 40;
    localparam int NVEC   = 5;
    // hs_pol, vs_pol, rate, offset, lines/2, coarse, fine, blocks, lines per field
    localparam int VEC [NVEC][9] = '{
        '{1, 1, 1, 20, 5, 0, 0, 1, 312},
        '{0, 0, 1,  3, 2, 2, 1, 2, 262},
        '{1, 0, 2,  0, 1, 1, 3, 1, 262},
        '{0, 1, 1, 10, 3, 0, 2, 2, 290},
        '{1, 1, 1,  5, 2, 1, 0, 1, 289}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_en_n = 1'b0;
    logic hsync_in = 1'b0;
    logic vsync_in = 1'b0;
    logic hs_pol = 1'b1;
    logic vs_pol = 1'b1;
    logic [9:0] v_offset = '0;
    logic [8:0] v_lines2 = '0;
    logic [7:0] h_coarse = '0;
    logic [1:0] h_fine = '0;
    logic [7:0] h_blocks = '0;
    logic line_valid, pixel_valid, frame_start, std_ntsc;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;
    int k = 1;
    bit force_dis = 0;
    int pv_total, first_pv_n, fs_cnt, fs_pos, lv_lines, first_lv, std_seen;

    always #2.5 clk = ~clk;

    fw_framer u0 (.*);

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 195000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog all requirements: actual=%0d cycles expected<195000", cyc);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_meas();
        pv_total = 0; first_pv_n = -1; fs_cnt = 0; fs_pos = -1;
        lv_lines = 0; first_lv = -1; std_seen = -1;
    endtask

    task automatic observe(input int l, input int n);
        if (pixel_valid) begin
            pv_total++;
            if (l == int'(v_offset) + 1 && first_pv_n < 0) first_pv_n = n;
        end
        if (frame_start) begin
            fs_cnt++;
            if (fs_pos < 0) fs_pos = l * 1000 + n;
        end
        if (n == 30 * k) begin
            if (line_valid) begin
                lv_lines++;
                if (first_lv < 0) first_lv = l;
            end
            if (l == 1) std_seen = int'(std_ntsc);
        end
    endtask

    task automatic run_field(input int nl, input bit has_v, input bit meas);
        for (int l = 0; l < nl; l++) begin
            for (int s = 0; s < LINE_S; s++) begin
                for (int c = 0; c < k; c++) begin
                    bit hs_a;
                    bit vs_a;
                    @(negedge clk);
                    if (meas) observe(l, s * k + c);
                    hs_a = (s < 4);
                    vs_a = has_v && ((l == 0 && s >= 20) || l == 1 || l == 2 || (l == 3 && s < 20));
                    hsync_in  = hs_pol ? hs_a : !hs_a;
                    vsync_in  = vs_pol ? vs_a : !vs_a;
                    sync_en_n = force_dis ? 1'b1 : (k == 2 && c == 1);
                end
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hsync_in = !hs_pol;
            vsync_in = !vs_pol;
            sync_en_n = 1'b0;
        end
    endtask

    initial begin
        hsync_in = 1'b0; vsync_in = 1'b0;
        v_offset = 10'd0; v_lines2 = 9'd2; h_coarse = 8'd0; h_fine = 2'd0; h_blocks = 8'd1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check({line_valid, pixel_valid, frame_start, std_ntsc} == 4'b0000, "R3 reset outputs",
              int'({line_valid, pixel_valid, frame_start, std_ntsc}), 0);

        // R3: horizontal syncs without any vertical sync leave framing inactive
        k = 1;
        clear_meas();
        run_field(6, 1'b0, 1'b1);
        check(lv_lines == 0, "R3 no line_valid before vsync", lv_lines, 0);
        check(pv_total == 0, "R3 no pixel_valid before vsync", pv_total, 0);

        for (int v = 0; v < NVEC; v++) begin
            int d;
            int exp_std;
            hs_pol   = VEC[v][0][0];
            vs_pol   = VEC[v][1][0];
            k        = VEC[v][2];
            v_offset = 10'(VEC[v][3]);
            v_lines2 = 9'(VEC[v][4]);
            h_coarse = 8'(VEC[v][5]);
            h_fine   = 2'(VEC[v][6]);
            h_blocks = 8'(VEC[v][7]);
            d = 4 * VEC[v][5] + VEC[v][6] + 7;
            exp_std = (VEC[v][8] < 290) ? 1 : 0;
            idle(4);
            run_field(VEC[v][8], 1'b1, 1'b0);
            clear_meas();
            run_field(VEC[v][8], 1'b1, 1'b1);
            check(std_seen == exp_std, $sformatf("R8 standard flag vec %0d", v), std_seen, exp_std);
            check(first_lv == VEC[v][3] + 1, $sformatf("R1 R4 first active line vec %0d", v),
                  first_lv, VEC[v][3] + 1);
            check(lv_lines == 2 * VEC[v][4], $sformatf("R4 active line count vec %0d", v),
                  lv_lines, 2 * VEC[v][4]);
            check(first_pv_n == d * k + 1, $sformatf("R5 R2 first pixel position vec %0d", v),
                  first_pv_n, d * k + 1);
            check(pv_total == 2 * VEC[v][4] * 8 * VEC[v][7] * k,
                  $sformatf("R6 pixel_valid total vec %0d", v),
                  pv_total, 2 * VEC[v][4] * 8 * VEC[v][7] * k);
            check(fs_cnt == k && fs_pos == (VEC[v][3] + 1) * 1000 + d * k + 1,
                  $sformatf("R7 frame_start position vec %0d", v),
                  fs_pos, (VEC[v][3] + 1) * 1000 + d * k + 1);
        end

        // R2: a vertical sync presented only on disabled edges must not restart the field
        k = 1;
        v_offset = 10'd0;
        v_lines2 = 9'd2;
        force_dis = 1'b1;
        run_field(1, 1'b1, 1'b0);
        force_dis = 1'b0;
        clear_meas();
        run_field(6, 1'b0, 1'b1);
        check(lv_lines == 0, "R2 disabled-edge vsync ignored (line_valid)", lv_lines, 0);
        check(pv_total == 0, "R2 disabled-edge vsync ignored (pixel_valid)", pv_total, 0);

        done = 1;
        summary();
        $finish;
    end
endmodule